// File: doc/BRIEF.md
# Operating Mode Controller

This block holds the chip's operating mode and moves it between three run modes (normal run, fast run, low-power run) and three halt modes (halt variant A, halt variant B, low-power halt). Software programs a permission register, a mode-select register and a halt-variant register through a small write/read port. Run-mode changes take effect when the mode-select register is written. Halt modes are entered only when the core signals a deep-sleep wait-for-interrupt, and they are left on a wakeup interrupt or on reset.

A one-hot status register reports the run mode. While the chip is halted, this register keeps the value it held when the halt began. The controller also records whether low-power halt was entered straight from normal run. In that case the wakeup returns to normal run, not to low-power run. Clock gating handshakes, regulator control and actual clock switching belong to other blocks and are not part of this one.

Top module: `pwr_mode_ctrl`

Register map (byte-wide fields at word offsets): offset 0 PERMIT (bit 0 allows fast run, bit 1 allows low-power modes); offset 1 MODESEL (bits [1:0] run select, bits [6:4] halt select); offset 2 HALTVAR (bits [1:0]); offset 3 STATUS (read only). Bits outside these fields read as 0, and unmapped offsets read as 0. The `mode_o` codes are: 0 normal run, 1 fast run, 2 low-power run, 3 halt A, 4 halt B, 5 low-power halt.

## Requirements
- R1: From normal run, a MODESEL write with run select 11 enters fast run and one with run select 10 enters low-power run, provided the matching PERMIT bit is set.
- R2: STATUS is one-hot: 0x01 in normal run, 0x04 in low-power run, 0x80 in fast run. It changes one clock cycle after `mode_o` changes.
- R3: A fast-run request is ignored unless PERMIT bit 0 is set. A low-power-run or low-power-halt request is ignored unless PERMIT bit 1 is set. An ignored request leaves the mode unchanged.
- R4: Halt entry happens only on a `wfi_deep` pulse. From normal run, halt select 000 selects a normal halt and 010 selects low-power halt. Any other halt select value makes the pulse have no effect.
- R5: For a normal halt, HALTVAR 01 enters halt A and 10 enters halt B. HALTVAR 00 or 11 makes the `wfi_deep` pulse have no effect. A wakeup from halt A or halt B returns to normal run.
- R6: From low-power run, halt select 000 or 010 enters low-power halt on `wfi_deep`, and the wakeup then returns to low-power run.
- R7: When low-power halt was entered from normal run, the wakeup returns to normal run.
- R8: Reset puts the controller in normal run with STATUS 0x01 and all writable registers cleared. A MODESEL write with run select 00 returns fast run or low-power run to normal run.
- R9: Fast run and low-power run are entered only from normal run. A run select of 10 or 11 written while in one of them changes nothing.
- R10: During any halt mode, STATUS holds the value of the run mode that was active when the halt began.
- R11: `wfi_deep` in fast run has no effect. `wake_irq` in any run mode has no effect.
- R12: PERMIT, MODESEL and HALTVAR read back their written field bits, with all other bits reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| wfi_deep | input | 1 | Single-cycle deep-sleep wait-for-interrupt pulse |
| wake_irq | input | 1 | Single-cycle wakeup interrupt pulse |
| mode_o | output | 3 | Current mode code |

## Verification
The checker assumes that `wfi_deep` and `wake_irq` are single-cycle pulses. It also assumes that neither arrives in the same cycle as a MODESEL write, because in that cycle the run change would take priority over the halt request. The stimulus drives each write, `wfi_deep` pulse or wakeup on its own, and allows settling cycles before the next operation. Reset is applied only while the halt and wake pulses are low, so the checker's rule that every halt entry and exit has a matching pulse holds across the whole run.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      PM_RUN     = 3'd0,
      PM_FAST    = 3'd1,
      PM_LOWRUN  = 3'd2,
      PM_HALTA   = 3'd3,
      PM_HALTB   = 3'd4,
      PM_LOWHALT = 3'd5
   } pm_mode_e;

   localparam logic [1:0] RSEL_NORM = 2'b00;
   localparam logic [1:0] RSEL_LOW  = 2'b10;
   localparam logic [1:0] RSEL_FAST = 2'b11;
   localparam logic [2:0] HSEL_NORM = 3'b000;
   localparam logic [2:0] HSEL_LOW  = 3'b010;
   localparam logic [1:0] HVAR_A    = 2'b01;
   localparam logic [1:0] HVAR_B    = 2'b10;

   localparam int RSEL_LSB = 0;
   localparam int HSEL_LSB = 4;
   localparam int STAT_W   = 8;

   function automatic logic is_halt(pm_mode_e m);
      return (m == PM_HALTA) || (m == PM_HALTB) || (m == PM_LOWHALT);
   endfunction

   function automatic logic [STAT_W-1:0] stat_code(pm_mode_e m);
      logic [STAT_W-1:0] c;
      case (m)
         PM_FAST:   c = 8'h80;
         PM_LOWRUN: c = 8'h04;
         default:   c = 8'h01;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
   import pmc_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int OFF_PERM = 0,
   parameter int OFF_SEL  = 1,
   parameter int OFF_VAR  = 2,
   parameter int OFF_STAT = 3,
   parameter bit RD_PIPE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STAT_W-1:0] stat,
   output logic [DATA_W-1:0] rdata,
   output logic              allow_fast,
   output logic              allow_low,
   output logic [2:0]        halt_sel,
   output logic [1:0]        halt_var,
   output logic              run_wr,
   output logic [1:0]        run_req
);
   localparam logic [ADDR_W-1:0] A_PERM = ADDR_W'(OFF_PERM);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);
   localparam logic [ADDR_W-1:0] A_VAR  = ADDR_W'(OFF_VAR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   logic [1:0] perm_q;
   logic [1:0] rsel_q;
   logic [2:0] hsel_q;
   logic [1:0] hvar_q;
   logic [DATA_W-1:0] rd_mux;

   assign run_wr     = wr_en && (addr == A_SEL);
   assign run_req    = wdata[RSEL_LSB +: 2];
   assign allow_fast = perm_q[0];
   assign allow_low  = perm_q[1];
   assign halt_sel   = hsel_q;
   assign halt_var   = hvar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perm_q <= '0;
         rsel_q <= '0;
         hsel_q <= '0;
         hvar_q <= '0;
      end else if (wr_en) begin
         if (addr == A_PERM) perm_q <= wdata[1:0];
         if (addr == A_SEL) begin
            rsel_q <= wdata[RSEL_LSB +: 2];
            hsel_q <= wdata[HSEL_LSB +: 3];
         end
         if (addr == A_VAR) hvar_q <= wdata[1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (addr == A_PERM) rd_mux[1:0] = perm_q;
      else if (addr == A_SEL) begin
         rd_mux[RSEL_LSB +: 2] = rsel_q;
         rd_mux[HSEL_LSB +: 3] = hsel_q;
      end
      else if (addr == A_VAR) rd_mux[1:0] = hvar_q;
      else if (addr == A_STAT) rd_mux[STAT_W-1:0] = stat;
   end

   generate
      if (RD_PIPE) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       allow_fast,
   input  logic       allow_low,
   input  logic       run_wr,
   input  logic [1:0] run_req,
   input  logic [2:0] halt_sel,
   input  logic [1:0] halt_var,
   input  logic       wfi_deep,
   input  logic       wake_irq,
   output pm_mode_e   mode,
   output logic       from_run
);
   pm_mode_e mode_q, mode_d;
   logic     fr_q, fr_d;

   always_comb begin
      mode_d = mode_q;
      fr_d   = fr_q;
      case (mode_q)
         PM_RUN: begin
            if (run_wr && run_req == RSEL_FAST && allow_fast)
               mode_d = PM_FAST;
            else if (run_wr && run_req == RSEL_LOW && allow_low)
               mode_d = PM_LOWRUN;
            else if (wfi_deep && !run_wr) begin
               if (halt_sel == HSEL_NORM) begin
                  if (halt_var == HVAR_A)      mode_d = PM_HALTA;
                  else if (halt_var == HVAR_B) mode_d = PM_HALTB;
               end else if (halt_sel == HSEL_LOW && allow_low) begin
                  mode_d = PM_LOWHALT;
                  fr_d   = 1'b1;
               end
            end
         end
         PM_FAST: begin
            if (run_wr && run_req == RSEL_NORM) mode_d = PM_RUN;
         end
         PM_LOWRUN: begin
            if (run_wr) begin
               if (run_req == RSEL_NORM) mode_d = PM_RUN;
            end else if (wfi_deep && allow_low &&
                         (halt_sel == HSEL_NORM || halt_sel == HSEL_LOW)) begin
               mode_d = PM_LOWHALT;
               fr_d   = 1'b0;
            end
         end
         PM_HALTA, PM_HALTB: begin
            if (wake_irq) mode_d = PM_RUN;
         end
         PM_LOWHALT: begin
            if (wake_irq) begin
               mode_d = fr_q ? PM_RUN : PM_LOWRUN;
               fr_d   = 1'b0;
            end
         end
         default: mode_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_RUN;
         fr_q   <= 1'b0;
      end else begin
         mode_q <= mode_d;
         fr_q   <= fr_d;
      end
   end

   assign mode     = mode_q;
   assign from_run = fr_q;
endmodule

// File: rtl/pmc_status.sv
module pmc_status
   import pmc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  pm_mode_e          mode,
   output logic [STAT_W-1:0] stat
);
   logic [STAT_W-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             stat_q <= 8'h01;
      else if (!is_halt(mode)) stat_q <= stat_code(mode);
   end

   assign stat = stat_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int OFF_PERM = 0,
   parameter int OFF_SEL  = 1,
   parameter int OFF_VAR  = 2,
   parameter int OFF_STAT = 3,
   parameter bit RD_PIPE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wfi_deep,
   input  logic              wake_irq,
   output logic [2:0]        mode_o
);
   localparam int N_OFF = 2 ** ADDR_W;

   generate
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("DATA_W must hold the status field");
      end
      if (OFF_PERM >= N_OFF || OFF_SEL >= N_OFF || OFF_VAR >= N_OFF || OFF_STAT >= N_OFF) begin : g_bad_off
         $error("register offset outside address range");
      end
      if (OFF_PERM == OFF_SEL || OFF_PERM == OFF_VAR || OFF_PERM == OFF_STAT ||
          OFF_SEL == OFF_VAR || OFF_SEL == OFF_STAT || OFF_VAR == OFF_STAT) begin : g_dup_off
         $error("register offsets must differ");
      end
   endgenerate

   logic              allow_fast_w, allow_low_w, run_wr_w, from_run_w;
   logic [1:0]        run_req_w, halt_var_w;
   logic [2:0]        halt_sel_w;
   logic [STAT_W-1:0] stat_w;
   pm_mode_e          mode_w;

   pmc_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_PERM(OFF_PERM), .OFF_SEL(OFF_SEL),
      .OFF_VAR(OFF_VAR), .OFF_STAT(OFF_STAT), .RD_PIPE(RD_PIPE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .stat(stat_w), .rdata(bus_rdata), .allow_fast(allow_fast_w), .allow_low(allow_low_w),
      .halt_sel(halt_sel_w), .halt_var(halt_var_w), .run_wr(run_wr_w), .run_req(run_req_w)
   );

   pmc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .allow_fast(allow_fast_w), .allow_low(allow_low_w),
      .run_wr(run_wr_w), .run_req(run_req_w), .halt_sel(halt_sel_w), .halt_var(halt_var_w),
      .wfi_deep(wfi_deep), .wake_irq(wake_irq), .mode(mode_w), .from_run(from_run_w)
   );

   pmc_status u_stat (
      .clk(clk), .rst_n(rst_n), .mode(mode_w), .stat(stat_w)
   );

   assign mode_o = mode_w;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
   import pmc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode,
   input logic [7:0] stat,
   input logic       allow_fast,
   input logic       allow_low,
   input logic       wfi_deep,
   input logic       wake_irq,
   input logic       from_run
);
   function automatic logic halted(logic [2:0] m);
      return (m == PM_HALTA) || (m == PM_HALTB) || (m == PM_LOWHALT);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_run_r8: assert (mode == PM_RUN && stat == 8'h01)
            else $error("reset state wrong");
      end
   end

   p_stat_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stat) == 1);

   p_fast_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_FAST && $past(mode) != PM_FAST) |-> $past(allow_fast));

   p_low_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == PM_LOWRUN || mode == PM_LOWHALT) && $past(mode) == PM_RUN) |-> $past(allow_low));

   p_fast_from_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_FAST && $past(mode) != PM_FAST) |-> $past(mode) == PM_RUN);

   p_halt_on_wfi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (halted(mode) && !halted($past(mode))) |-> $past(wfi_deep));

   p_exit_on_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted(mode) && halted($past(mode))) |-> $past(wake_irq));

   p_stat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted(mode) && halted($past(mode))) |-> $stable(stat));

   p_lowhalt_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == PM_LOWHALT && $past(from_run) && mode != PM_LOWHALT) |-> mode == PM_RUN);
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_o), .stat(stat_w),
   .allow_fast(allow_fast_w), .allow_low(allow_low_w),
   .wfi_deep(wfi_deep), .wake_irq(wake_irq), .from_run(from_run_w)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int NV = 33;
   // {op[2], addr[2], data[8], exp_mode[3], exp_stat[8], req[4]}; op 0=write 1=wfi 2=wake
   localparam logic [26:0] TBL [0:NV-1] = '{
      {2'd0,2'd0,8'h00,3'd0,8'h01,4'd3},  // R3 permit cleared
      {2'd0,2'd1,8'h03,3'd0,8'h01,4'd3},  // R3 fast blocked
      {2'd0,2'd1,8'h02,3'd0,8'h01,4'd3},  // R3 low blocked
      {2'd0,2'd0,8'h03,3'd0,8'h01,4'd12}, // R12
      {2'd0,2'd1,8'h03,3'd1,8'h80,4'd1},  // R1 enter fast
      {2'd0,2'd1,8'h02,3'd1,8'h80,4'd9},  // R9 fast->low ignored
      {2'd1,2'd0,8'h00,3'd1,8'h80,4'd11}, // R11 wfi in fast
      {2'd0,2'd1,8'h00,3'd0,8'h01,4'd8},  // R8 back to run
      {2'd0,2'd2,8'h01,3'd0,8'h01,4'd5},
      {2'd1,2'd0,8'h00,3'd3,8'h01,4'd5},  // R5 halt A
      {2'd2,2'd0,8'h00,3'd0,8'h01,4'd5},
      {2'd0,2'd2,8'h02,3'd0,8'h01,4'd5},
      {2'd1,2'd0,8'h00,3'd4,8'h01,4'd5},  // R5 halt B
      {2'd2,2'd0,8'h00,3'd0,8'h01,4'd5},
      {2'd0,2'd2,8'h03,3'd0,8'h01,4'd5},
      {2'd1,2'd0,8'h00,3'd0,8'h01,4'd5},  // R5 bad variant
      {2'd0,2'd1,8'h20,3'd0,8'h01,4'd4},
      {2'd1,2'd0,8'h00,3'd5,8'h01,4'd4},  // R4 low halt from run
      {2'd2,2'd0,8'h00,3'd0,8'h01,4'd7},  // R7 back to run
      {2'd0,2'd1,8'h22,3'd2,8'h04,4'd1},  // R1 enter low run
      {2'd1,2'd0,8'h00,3'd5,8'h04,4'd10}, // R10 status held
      {2'd2,2'd0,8'h00,3'd2,8'h04,4'd6},  // R6 back to low run
      {2'd0,2'd1,8'h02,3'd2,8'h04,4'd6},
      {2'd1,2'd0,8'h00,3'd5,8'h04,4'd6},  // R6 select 000
      {2'd2,2'd0,8'h00,3'd2,8'h04,4'd6},
      {2'd0,2'd1,8'h12,3'd2,8'h04,4'd4},
      {2'd1,2'd0,8'h00,3'd2,8'h04,4'd4},  // R4 bad select
      {2'd0,2'd1,8'h13,3'd2,8'h04,4'd9},  // R9 low->fast ignored
      {2'd2,2'd0,8'h00,3'd2,8'h04,4'd11}, // R11 wake in run
      {2'd0,2'd1,8'h10,3'd0,8'h01,4'd8},  // R8 low->run
      {2'd0,2'd1,8'h30,3'd0,8'h01,4'd4},
      {2'd1,2'd0,8'h00,3'd0,8'h01,4'd4},  // R4 bad select from run
      {2'd2,2'd0,8'h00,3'd0,8'h01,4'd11}  // R11
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       wfi_deep = 1'b0;
   logic       wake_irq = 1'b0;
   logic [2:0] mode_o;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pwr_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wfi_deep(wfi_deep),
      .wake_irq(wake_irq), .mode_o(mode_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_op(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = {2'b00, a};
      bus_wdata = d;
      bus_wr = (op == 2'd0);
      wfi_deep = (op == 2'd1);
      wake_irq = (op == 2'd2);
      @(negedge clk);
      bus_wr = 1'b0;
      wfi_deep = 1'b0;
      wake_irq = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      #2 rst_n = 1'b0;
      #(CLK_P * 3) rst_n = 1'b1;
      @(negedge clk);
      // R8 / R12 reset state
      check("R8 mode after reset", {5'd0, mode_o}, 8'd0);
      rd(4'd3, v); check("R8 status after reset", v, 8'h01);
      rd(4'd0, v); check("R12 permit reset", v, 8'h00);
      rd(4'd1, v); check("R12 modesel reset", v, 8'h00);
      rd(4'd2, v); check("R12 haltvar reset", v, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [26:0] e;
         string tag;
         e = TBL[i];
         do_op(e[26:25], e[24:23], e[22:15]);
         tag = $sformatf("R%0d vec%0d", e[3:0], i);
         check({tag, " mode"}, {5'd0, mode_o}, {5'd0, e[14:12]});
         rd(4'd3, v);
         check({tag, " status"}, v, e[11:4]);
      end

      // R2 status lag of one cycle
      @(negedge clk);
      bus_addr = 4'd1; bus_wdata = 8'h03; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R2 mode fast", {5'd0, mode_o}, 8'd1);
      rd(4'd3, v); check("R2 status lags", v, 8'h01);
      @(negedge clk);
      rd(4'd3, v); check("R2 status updated", v, 8'h80);
      // R12 readback of fields
      rd(4'd0, v); check("R12 permit readback", v, 8'h03);
      rd(4'd1, v); check("R12 modesel readback", v, 8'h03);
      do_op(2'd0, 2'd2, 8'hFE);
      rd(4'd2, v); check("R12 haltvar masked", v, 8'h02);
      do_op(2'd0, 2'd1, 8'hFC);
      check("R8 fast to run", {5'd0, mode_o}, 8'd0);
      rd(4'd1, v); check("R12 modesel masked", v, 8'h70);
      rd(4'd5, v); check("R12 unmapped reads zero", v, 8'h00);

      // R3 low halt blocked without low permit
      do_op(2'd0, 2'd0, 8'h01);
      do_op(2'd0, 2'd1, 8'h20);
      do_op(2'd1, 2'd0, 8'h00);
      check("R3 low halt blocked", {5'd0, mode_o}, 8'd0);

      // R8 reset from a halt mode
      do_op(2'd0, 2'd1, 8'h00);
      do_op(2'd0, 2'd2, 8'h01);
      do_op(2'd1, 2'd0, 8'h00);
      check("R5 halt A before reset", {5'd0, mode_o}, 8'd3);
      rst_n = 1'b0;
      #(CLK_P * 2);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 reset leaves halt", {5'd0, mode_o}, 8'd0);
      rd(4'd3, v); check("R8 status after halt reset", v, 8'h01);
      rd(4'd2, v); check("R8 haltvar cleared", v, 8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule